// File: doc/BRIEF.md
# Keyed-Write Watchdog Reset Control Register

This block holds the reset-control state of a watchdog: an overflow flag, a reset-enable bit and a reset-select bit. It sits on a simple peripheral bus with an address, an access-size code, 16-bit write data, an 8-bit read port and separate read and write strobes. The register lives at offset 4 of a three-register watchdog group. The control/status register sits at offset 0 and the counter at offset 2. Both are outside this block.

Software changes the register only through 16-bit writes that carry a key in the upper byte. Key 0xA5 with a zero lower byte clears the overflow flag. Key 0x5A loads the two configuration bits from the lower byte. Every other write has no effect.

A one-cycle overflow pulse from the watchdog counter sets the flag. Reads are byte-sized. They return the flag and both configuration bits on a registered read port. The configuration bits also drive the reset logic directly through registered outputs.

Top module: `wdg_rstctl_regs`

## Requirements
- R1: After reset the flag, reset-enable and reset-select are all 0, and the read port returns 0.
- R2: A write of size 16-bit (size code 01) to offset 4 with data 0xA500 clears the flag (readable bit 7). Reset-enable and reset-select keep their values.
- R3: A write of size 16-bit to offset 4 with upper byte 0x5A copies data bit 6 into reset-enable and data bit 5 into reset-select. The flag keeps its value.
- R4: Writes with size code 00 (byte), 10 (32-bit) or 11 (reserved) change nothing, whatever the data.
- R5: A 16-bit write whose upper byte is neither 0xA5 nor 0x5A changes nothing. So does a 0xA5 write with a nonzero lower byte.
- R6: Writes to any address other than group base + 4 change nothing.
- R7: A one-cycle pulse on the overflow input sets the flag. If the pulse and an accepted clear arrive in the same cycle, the flag ends up set. Software can never set the flag.
- R8: A byte read (size code 00) at base + 4 returns, on the cycle after the strobe, flag in bit 7, reset-enable in bit 6, reset-select in bit 5 and 0 in bits 4..0. A read of any other size or address returns 0, and so does any cycle without a read strobe.
- R9: The reset-enable and reset-select outputs change on the clock edge that samples an accepted configuration write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 00 byte, 01 16-bit, 10 32-bit, 11 reserved |
| bus_wdata | input | 16 | Write data: key in [15:8], payload in [7:0] |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| wdt_ovf | input | 1 | Overflow pulse from the watchdog counter |
| rst_enable | output | 1 | Reset-enable setting |
| rst_select | output | 1 | Reset-select setting |

## Verification
Every bit of state is visible both on the read port and, for the two configuration bits, on dedicated outputs. A wrongly accepted or wrongly rejected write therefore shows on rst_enable or rst_select on the very next clock edge. A wrong flag shows on the first byte read after it, one cycle after that read's strobe. The sweep follows every write with such a read, so a corrupted bit can never stay hidden for more than a few cycles. Set-versus-clear priority gets its own collision case, because no other stimulus pattern reaches it.

// File: rtl/wdg_rc_pkg.sv
package wdg_rc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_RSVD = 2'b11
  } bus_size_e;

  localparam logic [7:0] KEY_CLEAR  = 8'hA5;
  localparam logic [7:0] KEY_CONFIG = 8'h5A;

  // bit positions inside the readable byte
  localparam int FLAG_POS = 7;
  localparam int EN_POS   = 6;
  localparam int SEL_POS  = 5;

  // configuration fields: index 1 = enable, index 0 = select
  localparam int NUM_CFG = 2;
  localparam int RC_OFFSET = 4;

  function automatic int cfg_pos(input int idx);
    return (idx == 1) ? EN_POS : SEL_POS;
  endfunction
endpackage

// File: rtl/wdg_rc_rst_sync.sv
module wdg_rc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_rc_decode.sv
module wdg_rc_decode
  import wdg_rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [15:0]       wdata,
  output logic              clr_req,
  output logic              cfg_req,
  output logic [NUM_CFG-1:0] cfg_val
);
  localparam logic [ADDR_W-1:0] RC_ADDR = BASE + ADDR_W'(RC_OFFSET);

  logic       word_hit;
  logic [7:0] key;
  logic [7:0] payload;

  always_comb begin
    key      = wdata[15:8];
    payload  = wdata[7:0];
    word_hit = wr_en && (addr == RC_ADDR) && (size == SZ_HALF);
    clr_req  = word_hit && (key == KEY_CLEAR) && (payload == 8'h00);
    cfg_req  = word_hit && (key == KEY_CONFIG);
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_field
    assign cfg_val[i] = payload[cfg_pos(i)];
  end
endmodule

// File: rtl/wdg_rc_state.sv
module wdg_rc_state
  import wdg_rc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovf_pulse,
  input  logic               clr_req,
  input  logic               cfg_req,
  input  logic [NUM_CFG-1:0] cfg_val,
  output logic               flag_q,
  output logic [NUM_CFG-1:0] cfg_q
);
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = ovf_pulse | clr_req;
    flag_d  = ovf_pulse ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    logic bit_d;
    always_comb bit_d = cfg_val[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[i] <= 1'b0;
      else if (cfg_req) cfg_q[i] <= bit_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> flag_q); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovf_pulse) |=> !flag_q); // R2
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_pulse |=> !$rose(flag_q)); // R7
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> (cfg_q == $past(cfg_val))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> $stable(cfg_q)); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !ovf_pulse) |=> $stable(flag_q)); // R3
endmodule

// File: rtl/wdg_rc_rdport.sv
module wdg_rc_rdport
  import wdg_rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic               flag,
  input  logic [NUM_CFG-1:0] cfg,
  output logic [7:0]         rdata
);
  localparam logic [ADDR_W-1:0] RC_ADDR = BASE + ADDR_W'(RC_OFFSET);

  logic [7:0] view;
  logic [7:0] rdata_d;

  always_comb begin
    view = '0;
    view[FLAG_POS] = flag;
    for (int i = 0; i < NUM_CFG; i++) view[cfg_pos(i)] = cfg[i];
    rdata_d = (rd_en && (addr == RC_ADDR) && (size == SZ_BYTE)) ? view : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/wdg_rstctl_regs.sv
module wdg_rstctl_regs
  import wdg_rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              wdt_ovf,
  output logic              rst_enable,
  output logic              rst_select
);
  logic               rst_ns;
  logic               clr_req;
  logic               cfg_req;
  logic [NUM_CFG-1:0] cfg_val;
  logic               flag_q;
  logic [NUM_CFG-1:0] cfg_q;

  wdg_rc_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_ns)
  );

  wdg_rc_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .wr_en(bus_wr), .addr(bus_addr), .size(bus_size), .wdata(bus_wdata),
    .clr_req(clr_req), .cfg_req(cfg_req), .cfg_val(cfg_val)
  );

  wdg_rc_state u_st (
    .clk(clk), .rst_n(rst_ns), .ovf_pulse(wdt_ovf),
    .clr_req(clr_req), .cfg_req(cfg_req), .cfg_val(cfg_val),
    .flag_q(flag_q), .cfg_q(cfg_q)
  );

  wdg_rc_rdport #(.ADDR_W(ADDR_W), .BASE(BASE)) u_rd (
    .clk(clk), .rst_n(rst_ns), .rd_en(bus_rd), .addr(bus_addr),
    .size(bus_size), .flag(flag_q), .cfg(cfg_q), .rdata(bus_rdata)
  );

  assign rst_enable = cfg_q[1];
  assign rst_select = cfg_q[0];

  AST_WIDTH_GATE: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_wr && bus_size != SZ_HALF) |=> ($stable(cfg_q) && !$fell(flag_q))); // R4
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_wr && bus_wdata[15:8] != KEY_CLEAR && bus_wdata[15:8] != KEY_CONFIG)
      |=> $stable(cfg_q)); // R5
  AST_RD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_rd && bus_size != SZ_BYTE) |=> (bus_rdata == 8'h00)); // R8
  AST_IDLE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    !bus_rd |=> (bus_rdata == 8'h00)); // R8
endmodule

// File: tb/sim_wdg_rstctl_regs.sv
module sim_wdg_rstctl_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [1:0] bus_size;
  logic [15:0] bus_wdata;
  logic       bus_wr, bus_rd, wdt_ovf;
  logic [7:0] bus_rdata;
  logic       rst_enable, rst_select;

  int checks = 0;
  int fails  = 0;
  logic m_flag, m_en, m_sel;

  always #10 clk = ~clk; // 50 MHz

  wdg_rstctl_regs #(.ADDR_W(8), .BASE(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .wdt_ovf(wdt_ovf),
    .rst_enable(rst_enable), .rst_select(rst_select)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte();
    return {m_flag, m_en, m_sel, 5'b00000};
  endfunction

  function automatic logic [7:0] lo_pick(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h20; 2: return 8'h40; 3: return 8'h60;
      4: return 8'h80; 5: return 8'hA5; 6: return 8'hFF; default: return 8'h01;
    endcase
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [1:0] sz,
                           input logic [15:0] d, input logic ovf);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1; wdt_ovf = ovf;
    @(negedge clk);
    bus_wr = 1'b0; wdt_ovf = 1'b0;
    if (a == 8'h04 && sz == 2'b01) begin
      if (d == 16'hA500) m_flag = 1'b0;
      else if (d[15:8] == 8'h5A) begin m_en = d[6]; m_sel = d[5]; end
    end
    if (ovf) m_flag = 1'b1;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); wdt_ovf = 1'b1;
    @(negedge clk); wdt_ovf = 1'b0;
    m_flag = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [1:0] sz,
                          input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic check_outs(input string req);
    check(req, {6'b0, rst_enable, rst_select}, {6'b0, m_en, m_sel});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; wdt_ovf = 1'b0;
    m_flag = 1'b0; m_en = 1'b0; m_sel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outs("R1");
    check("R1", bus_rdata, 8'h00);
    bus_read(8'h04, 2'b00, 8'h00, "R1");

    // R7 overflow sets, R8 readback layout
    pulse_ovf();
    bus_read(8'h04, 2'b00, 8'h80, "R7");
    // R3 load both bits, flag kept
    bus_write(8'h04, 2'b01, 16'h5A60, 1'b0);
    check_outs("R9");
    bus_read(8'h04, 2'b00, 8'hE0, "R3");
    // R2 clear keeps config
    bus_write(8'h04, 2'b01, 16'hA500, 1'b0);
    bus_read(8'h04, 2'b00, 8'h60, "R2");
    // R7 set wins over clear in same cycle
    bus_write(8'h04, 2'b01, 16'hA500, 1'b1);
    bus_read(8'h04, 2'b00, 8'hE0, "R7");

    // R6 / R8 address sweep
    for (int a = 0; a < 16; a++) begin
      bus_write(8'(a), 2'b01, (m_en ? 16'h5A00 : 16'h5A60), 1'b0);
      check_outs(a == 4 ? "R3" : "R6");
      bus_read(8'(a), 2'b00, (a == 4) ? exp_byte() : 8'h00, "R8");
      bus_read(8'(a), 2'b01, 8'h00, "R8");
      bus_read(8'(a), 2'b10, 8'h00, "R8");
    end

    // near-exhaustive key x payload x size sweep at offset 4
    for (int k = 0; k < 256; k++) begin
      for (int li = 0; li < 8; li++) begin
        for (int sz = 0; sz < 4; sz++) begin
          string req;
          if (sz != 1) req = "R4";
          else if (k == 8'hA5) req = "R2";
          else if (k == 8'h5A) req = "R3";
          else req = "R5";
          if (((k + li + sz) % 3) == 0) pulse_ovf();
          bus_write(8'h04, 2'(sz), {8'(k), lo_pick(li)}, 1'b0);
          check_outs(req);
          bus_read(8'h04, 2'b00, exp_byte(), req);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule